// File: doc/BRIEF.md
# Warp Memory-Instruction Slot

This block is a single entry of a GPU load-store queue. It holds one warp-wide memory instruction from the moment it is dispatched until the slot is released for reuse. On dispatch it decodes the instruction class from the request flags and captures the warp id, access size, program counter and L1-bypass bit. It then follows one of two paths. On the access path, per-lane request bits are gathered and the instruction is coalesced. On the fence path, the fence is started and later completes.

On the access path, the number of coalesced accesses comes from external coalescing logic. The slot tracks them as pending, then translated, then completed. It raises a one-cycle done pulse when all of them have drained. The slot reports the cycles elapsed since the instruction first entered execution, and it can hold a completion timestamp written by the surrounding queue. Any command that does not fit the current state sets a sticky error output and is not performed.

Top module: `warp_mem_slot`

## Requirements
- R1: After reset the state is EMPTY (0), the class is INVALID (0), the warp id is all ones, and the lane mask, counts, latency, stamp, done and error outputs are all zero.
- R2: A dispatch with a legal descriptor is taken only in EMPTY. It moves the state to DISPATCHING (1) and captures the warp id, size, pc and bypass bit on the same edge.
- R3: Class encoding is INVALID=0, LOAD=1, STORE=2, FENCE=3, ATOMIC=4. A descriptor must carry exactly one of read, write and fence. A read with swap gives ATOMIC, a read without swap gives LOAD, a write gives STORE and a fence gives FENCE.
- R4: A dispatch whose descriptor has swap with write or fence, or does not carry exactly one of read, write and fence, sets the error output and leaves the slot EMPTY.
- R5: A coalesce command in DISPATCHING moves the state to COALESCED (2). It loads the pending count from the access-count input and clears the translated count.
- R6: A fence-start command in DISPATCHING moves the state to FENCING (3). A fence-arrival event in FENCING moves it to FENCE_COMPLETE (4).
- R7: A translate event moves one access from the pending count to the translated count. A complete event removes one access from the translated count. A translate at pending zero, or a complete at translated zero, sets the error output and changes no count.
- R8: Release is taken only in COALESCED or FENCE_COMPLETE with both counts zero. It returns the state to EMPTY, sets the warp id to all ones, and clears the class, size, pc, bypass bit, lane mask, timestamps and stamp.
- R9: A command that does not fit the current state, or more than one of dispatch, coalesce, fence-start, fence-arrival and release in one cycle, sets the error output and leaves the state unchanged. The error output stays set until reset.
- R10: The latency output is the number of clock edges since the edge that took the coalesce or fence-start command, counting that edge as 1. It reads zero in EMPTY and DISPATCHING.
- R11: A stamp write loads the completion stamp register, which is readable on the stamp output, and release clears it.
- R12: In COALESCED, when both counts are zero, the done output is high for exactly one cycle per instruction.
- R13: Lane-set ORs the lane mask input into the lane mask register only in DISPATCHING. In any other state it sets the error output and leaves the mask unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| disp_valid_i | input | 1 | Dispatch command |
| disp_rd_i | input | 1 | Descriptor read flag |
| disp_wr_i | input | 1 | Descriptor write flag |
| disp_swap_i | input | 1 | Descriptor swap flag |
| disp_fence_i | input | 1 | Descriptor fence flag |
| disp_warp_i | input | WARP_W | Warp id |
| disp_size_i | input | SIZE_W | Request size |
| disp_pc_i | input | PC_W | Program counter |
| disp_bypass_i | input | 1 | L1-bypass request |
| lane_set_i | input | 1 | Lane-set event |
| lane_mask_i | input | LANES | Lanes to mark as requesting |
| coalesce_i | input | 1 | Coalesce command |
| acc_cnt_i | input | CNT_W | Coalesced access count |
| fence_start_i | input | 1 | Fence-start command |
| fence_arrive_i | input | 1 | Fence-arrival event |
| release_i | input | 1 | Release command |
| acc_translate_i | input | 1 | One access translated |
| acc_complete_i | input | 1 | One access completed |
| stamp_we_i | input | 1 | Completion stamp write |
| stamp_i | input | TS_W | Completion stamp value |
| state_o | output | 3 | Slot state |
| class_o | output | 3 | Instruction class |
| warp_o | output | WARP_W | Captured warp id |
| size_o | output | SIZE_W | Captured size |
| pc_o | output | PC_W | Captured pc |
| bypass_o | output | 1 | Captured bypass bit |
| lane_mask_o | output | LANES | Requesting lanes |
| pending_o | output | CNT_W | Accesses awaiting translation |
| translated_o | output | CNT_W | Accesses awaiting completion |
| latency_o | output | TS_W | Cycles since execution began |
| stamp_o | output | TS_W | Completion stamp |
| done_o | output | 1 | All accesses drained pulse |
| err_o | output | 1 | Sticky illegal-command flag |

## Verification
The assertions check on every cycle that an illegal command leaves the state untouched and that the error flag never falls. They also check that a translate shifts exactly one access between the counts, that release clears the captured fields, that fence completion is reached only from FENCING, and that done never lasts two cycles. Only the bench scenarios can show the decoded class values for each flag combination, the exact latency counts, the drain sequence that ends in done, and that refused lane-set and underflow events leave the visible mask and counts unchanged.

// File: rtl/wslot_pkg.sv
package wslot_pkg;
  typedef enum logic [2:0] {
    ST_EMPTY = 3'd0,
    ST_DISP  = 3'd1,
    ST_COAL  = 3'd2,
    ST_FENCE = 3'd3,
    ST_FDONE = 3'd4
  } slot_state_e;

  typedef enum logic [2:0] {
    IC_INVALID = 3'd0,
    IC_LOAD    = 3'd1,
    IC_STORE   = 3'd2,
    IC_FENCE   = 3'd3,
    IC_ATOMIC  = 3'd4
  } inst_class_e;
endpackage

// File: rtl/wslot_decode.sv
module wslot_decode
  import wslot_pkg::*;
(
  input  logic        rd_i,
  input  logic        wr_i,
  input  logic        swap_i,
  input  logic        fence_i,
  output inst_class_e cls_o,
  output logic        legal_o
);
  logic [1:0] n_kind;

  always_comb begin
    n_kind  = 2'(rd_i) + 2'(wr_i) + 2'(fence_i);
    legal_o = (n_kind == 2'd1) && !(swap_i && !rd_i);
    cls_o   = IC_INVALID;
    if (legal_o) begin
      if (rd_i)      cls_o = swap_i ? IC_ATOMIC : IC_LOAD;
      else if (wr_i) cls_o = IC_STORE;
      else           cls_o = IC_FENCE;
    end
  end
endmodule

// File: rtl/wslot_fsm.sv
module wslot_fsm
  import wslot_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        disp_i,
  input  logic        desc_ok_i,
  input  logic        coal_i,
  input  logic        fstart_i,
  input  logic        farrive_i,
  input  logic        release_i,
  input  logic        lane_set_i,
  input  logic        drained_i,
  input  logic        cnt_bad_i,
  output slot_state_e state_o,
  output logic        err_o,
  output logic        disp_take_o,
  output logic        coal_take_o,
  output logic        fstart_take_o,
  output logic        release_take_o,
  output logic        lane_take_o
);
  slot_state_e state_q, state_d;
  logic        err_q;
  logic [2:0]  n_cmd;
  logic        multi, cmd_bad, lane_bad, farr_take;
  logic        disp_ok, coal_ok, fstart_ok, farr_ok, rel_ok;

  always_comb begin
    n_cmd     = 3'(disp_i) + 3'(coal_i) + 3'(fstart_i) + 3'(farrive_i) + 3'(release_i);
    multi     = n_cmd > 3'd1;
    disp_ok   = (state_q == ST_EMPTY) && desc_ok_i;
    coal_ok   = state_q == ST_DISP;
    fstart_ok = state_q == ST_DISP;
    farr_ok   = state_q == ST_FENCE;
    rel_ok    = ((state_q == ST_COAL) || (state_q == ST_FDONE)) && drained_i;

    disp_take_o    = disp_i    && disp_ok   && !multi;
    coal_take_o    = coal_i    && coal_ok   && !multi;
    fstart_take_o  = fstart_i  && fstart_ok && !multi;
    farr_take      = farrive_i && farr_ok   && !multi;
    release_take_o = release_i && rel_ok    && !multi;

    cmd_bad = multi || (disp_i && !disp_ok) || (coal_i && !coal_ok) ||
              (fstart_i && !fstart_ok) || (farrive_i && !farr_ok) ||
              (release_i && !rel_ok);
    lane_take_o = lane_set_i && (state_q == ST_DISP);
    lane_bad    = lane_set_i && !lane_take_o;

    state_d = state_q;
    if (disp_take_o)    state_d = ST_DISP;
    if (coal_take_o)    state_d = ST_COAL;
    if (fstart_take_o)  state_d = ST_FENCE;
    if (farr_take)      state_d = ST_FDONE;
    if (release_take_o) state_d = ST_EMPTY;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_EMPTY;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      err_q   <= err_q | cmd_bad | lane_bad | cnt_bad_i;
    end
  end

  assign state_o = state_q;
  assign err_o   = err_q;

  a_r9_bad_cmd_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_bad |=> ($stable(state_q) && err_q));
  a_r9_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |=> err_q);
  a_r5_coal_enters: assert property (@(posedge clk_i) disable iff (!rst_ni)
    coal_take_o |=> (state_q == ST_COAL));
  a_r6_fdone_from_fence: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(state_q == ST_FDONE) |-> ($past(state_q) == ST_FENCE));
endmodule

// File: rtl/wslot_tracker.sv
module wslot_tracker #(
  parameter int CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_cnt_i,
  input  logic             translate_i,
  input  logic             complete_i,
  input  logic             clear_i,
  output logic [CNT_W-1:0] pend_o,
  output logic [CNT_W-1:0] trans_o,
  output logic             bad_o
);
  logic [CNT_W-1:0] pend_q, trans_q;
  logic             tr_ok, cp_ok;

  always_comb begin
    tr_ok = translate_i && (pend_q != '0);
    cp_ok = complete_i && (trans_q != '0);
    bad_o = (translate_i && !tr_ok) || (complete_i && !cp_ok);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= '0;
      trans_q <= '0;
    end else if (clear_i) begin
      pend_q  <= '0;
      trans_q <= '0;
    end else if (load_i) begin
      pend_q  <= load_cnt_i;
      trans_q <= '0;
    end else begin
      pend_q  <= pend_q - CNT_W'(tr_ok);
      trans_q <= trans_q + CNT_W'(tr_ok) - CNT_W'(cp_ok);
    end
  end

  assign pend_o  = pend_q;
  assign trans_o = trans_q;

  a_r7_translate_moves: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tr_ok && !cp_ok && !load_i && !clear_i) |=>
      ((trans_q == CNT_W'($past(trans_q) + 1'b1)) && (pend_q == CNT_W'($past(pend_q) - 1'b1))));
  a_r7_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (complete_i && (trans_q == '0) && !translate_i && !load_i && !clear_i) |=> (trans_q == '0));
endmodule

// File: rtl/warp_mem_slot.sv
module warp_mem_slot
  import wslot_pkg::*;
#(
  parameter int LANES  = 32,
  parameter int WARP_W = 6,
  parameter int SIZE_W = 8,
  parameter int PC_W   = 32,
  parameter int CNT_W  = 6,
  parameter int TS_W   = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              disp_valid_i,
  input  logic              disp_rd_i,
  input  logic              disp_wr_i,
  input  logic              disp_swap_i,
  input  logic              disp_fence_i,
  input  logic [WARP_W-1:0] disp_warp_i,
  input  logic [SIZE_W-1:0] disp_size_i,
  input  logic [PC_W-1:0]   disp_pc_i,
  input  logic              disp_bypass_i,
  input  logic              lane_set_i,
  input  logic [LANES-1:0]  lane_mask_i,
  input  logic              coalesce_i,
  input  logic [CNT_W-1:0]  acc_cnt_i,
  input  logic              fence_start_i,
  input  logic              fence_arrive_i,
  input  logic              release_i,
  input  logic              acc_translate_i,
  input  logic              acc_complete_i,
  input  logic              stamp_we_i,
  input  logic [TS_W-1:0]   stamp_i,
  output logic [2:0]        state_o,
  output logic [2:0]        class_o,
  output logic [WARP_W-1:0] warp_o,
  output logic [SIZE_W-1:0] size_o,
  output logic [PC_W-1:0]   pc_o,
  output logic              bypass_o,
  output logic [LANES-1:0]  lane_mask_o,
  output logic [CNT_W-1:0]  pending_o,
  output logic [CNT_W-1:0]  translated_o,
  output logic [TS_W-1:0]   latency_o,
  output logic [TS_W-1:0]   stamp_o,
  output logic              done_o,
  output logic              err_o
);
  localparam logic [WARP_W-1:0] WARP_NONE = '1;

  inst_class_e      dec_cls, cls_q;
  slot_state_e      state;
  logic             desc_ok, drained, cnt_bad;
  logic             disp_take, coal_take, fstart_take, release_take, lane_take;
  logic [CNT_W-1:0] pend, trans;
  logic [WARP_W-1:0] warp_q;
  logic [SIZE_W-1:0] size_q;
  logic [PC_W-1:0]  pc_q;
  logic             bypass_q, fired_q, done_cond;
  logic [LANES-1:0] lane_q;
  logic [TS_W-1:0]  cyc_q, first_q, stamp_q;

  wslot_decode u_decode (
    .rd_i    (disp_rd_i),
    .wr_i    (disp_wr_i),
    .swap_i  (disp_swap_i),
    .fence_i (disp_fence_i),
    .cls_o   (dec_cls),
    .legal_o (desc_ok)
  );

  wslot_fsm u_fsm (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .disp_i         (disp_valid_i),
    .desc_ok_i      (desc_ok),
    .coal_i         (coalesce_i),
    .fstart_i       (fence_start_i),
    .farrive_i      (fence_arrive_i),
    .release_i      (release_i),
    .lane_set_i     (lane_set_i),
    .drained_i      (drained),
    .cnt_bad_i      (cnt_bad),
    .state_o        (state),
    .err_o          (err_o),
    .disp_take_o    (disp_take),
    .coal_take_o    (coal_take),
    .fstart_take_o  (fstart_take),
    .release_take_o (release_take),
    .lane_take_o    (lane_take)
  );

  wslot_tracker #(.CNT_W(CNT_W)) u_tracker (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (coal_take),
    .load_cnt_i  (acc_cnt_i),
    .translate_i (acc_translate_i),
    .complete_i  (acc_complete_i),
    .clear_i     (release_take),
    .pend_o      (pend),
    .trans_o     (trans),
    .bad_o       (cnt_bad)
  );

  assign drained   = (pend == '0) && (trans == '0);
  assign done_cond = (state == ST_COAL) && drained;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      warp_q   <= WARP_NONE;
      size_q   <= '0;
      pc_q     <= '0;
      bypass_q <= 1'b0;
      cls_q    <= IC_INVALID;
    end else if (release_take) begin
      warp_q   <= WARP_NONE;
      size_q   <= '0;
      pc_q     <= '0;
      bypass_q <= 1'b0;
      cls_q    <= IC_INVALID;
    end else if (disp_take) begin
      warp_q   <= disp_warp_i;
      size_q   <= disp_size_i;
      pc_q     <= disp_pc_i;
      bypass_q <= disp_bypass_i;
      cls_q    <= dec_cls;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lane_q  <= '0;
      cyc_q   <= '0;
      first_q <= '0;
      stamp_q <= '0;
      fired_q <= 1'b0;
    end else begin
      cyc_q <= cyc_q + 1'b1;
      if (release_take) begin
        lane_q  <= '0;
        first_q <= '0;
        stamp_q <= '0;
        fired_q <= 1'b0;
      end else begin
        if (lane_take)                first_q <= first_q;
        if (lane_take)                lane_q  <= lane_q | lane_mask_i;
        if (coal_take || fstart_take) first_q <= cyc_q;
        if (stamp_we_i)               stamp_q <= stamp_i;
        if (done_o)                   fired_q <= 1'b1;
      end
    end
  end

  // first-cycle timestamp is meaningful only once execution has begun
  assign latency_o = ((state == ST_EMPTY) || (state == ST_DISP)) ? '0 : (cyc_q - first_q);
  assign done_o       = done_cond && !fired_q;
  assign state_o      = state;
  assign class_o      = cls_q;
  assign warp_o       = warp_q;
  assign size_o       = size_q;
  assign pc_o         = pc_q;
  assign bypass_o     = bypass_q;
  assign lane_mask_o  = lane_q;
  assign pending_o    = pend;
  assign translated_o = trans;
  assign stamp_o      = stamp_q;

  a_r8_release_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    release_take |=> ((state == ST_EMPTY) && (warp_q == WARP_NONE) && (cls_q == IC_INVALID) &&
                      (lane_q == '0) && !bypass_q && (stamp_q == '0)));
  a_r12_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r2_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disp_take |=> ((warp_q == $past(disp_warp_i)) && (pc_q == $past(disp_pc_i)) && (state == ST_DISP)));
endmodule

// File: tb/warp_mem_slot_tb.sv
`timescale 1ns/1ps
module warp_mem_slot_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        disp_valid, disp_rd, disp_wr, disp_swap, disp_fence, disp_bypass;
  logic [5:0]  disp_warp;
  logic [7:0]  disp_size;
  logic [31:0] disp_pc;
  logic        lane_set;
  logic [31:0] lane_mask;
  logic        coalesce, fence_start, fence_arrive, release_c;
  logic [5:0]  acc_cnt;
  logic        acc_tr, acc_cp, stamp_we;
  logic [31:0] stamp;
  logic [2:0]  state_o, class_o;
  logic [5:0]  warp_o;
  logic [7:0]  size_o;
  logic [31:0] pc_o;
  logic        bypass_o;
  logic [31:0] lane_mask_o;
  logic [5:0]  pending_o, translated_o;
  logic [31:0] latency_o, stamp_o;
  logic        done_o, err_o;
  int          n_chk = 0;
  int          n_fail = 0;

  always #2 clk = ~clk;

  warp_mem_slot u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .disp_valid_i(disp_valid), .disp_rd_i(disp_rd), .disp_wr_i(disp_wr),
    .disp_swap_i(disp_swap), .disp_fence_i(disp_fence), .disp_warp_i(disp_warp),
    .disp_size_i(disp_size), .disp_pc_i(disp_pc), .disp_bypass_i(disp_bypass),
    .lane_set_i(lane_set), .lane_mask_i(lane_mask), .coalesce_i(coalesce),
    .acc_cnt_i(acc_cnt), .fence_start_i(fence_start), .fence_arrive_i(fence_arrive),
    .release_i(release_c), .acc_translate_i(acc_tr), .acc_complete_i(acc_cp),
    .stamp_we_i(stamp_we), .stamp_i(stamp),
    .state_o(state_o), .class_o(class_o), .warp_o(warp_o), .size_o(size_o),
    .pc_o(pc_o), .bypass_o(bypass_o), .lane_mask_o(lane_mask_o),
    .pending_o(pending_o), .translated_o(translated_o), .latency_o(latency_o),
    .stamp_o(stamp_o), .done_o(done_o), .err_o(err_o)
  );

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic idle();
    disp_valid = 0; disp_rd = 0; disp_wr = 0; disp_swap = 0; disp_fence = 0; disp_bypass = 0;
    disp_warp = 0; disp_size = 0; disp_pc = 0; lane_set = 0; lane_mask = 0;
    coalesce = 0; fence_start = 0; fence_arrive = 0; release_c = 0; acc_cnt = 0;
    acc_tr = 0; acc_cp = 0; stamp_we = 0; stamp = 0;
  endtask

  task automatic do_reset();
    idle();
    rst_ni = 0;
    tick(); tick();
    rst_ni = 1;
  endtask

  task automatic dispatch(input logic rd, wr, sw, fe, input logic [5:0] w, input logic [7:0] sz,
                          input logic [31:0] pc, input logic byp);
    disp_valid = 1; disp_rd = rd; disp_wr = wr; disp_swap = sw; disp_fence = fe;
    disp_warp = w; disp_size = sz; disp_pc = pc; disp_bypass = byp;
    tick();
    idle();
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1", "state", state_o, 0);
    chk("R1", "class", class_o, 0);
    chk("R1", "warp", warp_o, 6'h3F);
    chk("R1", "lanes", lane_mask_o, 0);
    chk("R1", "counts", {pending_o, translated_o}, 0);
    chk("R1", "lat/stamp", {latency_o, stamp_o}, 0);
    chk("R1", "done/err", {done_o, err_o}, 0);
  endtask

  task automatic t_load_path();
    do_reset();
    dispatch(1, 0, 0, 0, 6'd5, 8'd4, 32'h0000_1000, 1);
    chk("R2", "state", state_o, 1);
    chk("R3", "class load", class_o, 1);
    chk("R2", "fields", {warp_o, size_o, pc_o, bypass_o}, {6'd5, 8'd4, 32'h0000_1000, 1'b1});
    lane_set = 1; lane_mask = 32'h0000_000F; tick();
    lane_mask = 32'h0000_00F0; tick(); idle();
    chk("R13", "lane or", lane_mask_o, 32'h0000_00FF);
    chk("R10", "lat in disp", latency_o, 0);
    coalesce = 1; acc_cnt = 6'd2; tick(); idle();
    chk("R5", "state", state_o, 2);
    chk("R5", "pending", {pending_o, translated_o}, {6'd2, 6'd0});
    chk("R10", "lat first", latency_o, 1);
    tick(); tick(); tick();
    chk("R10", "lat later", latency_o, 4);
    acc_tr = 1; tick(); idle();
    chk("R7", "move one", {pending_o, translated_o}, {6'd1, 6'd1});
    acc_tr = 1; acc_cp = 1; tick(); idle();
    chk("R7", "move+done", {pending_o, translated_o}, {6'd0, 6'd1});
    chk("R12", "no early done", done_o, 0);
    acc_cp = 1; tick(); idle();
    chk("R7", "drained", {pending_o, translated_o}, 0);
    chk("R12", "done high", done_o, 1);
    tick();
    chk("R12", "done one cycle", done_o, 0);
    stamp_we = 1; stamp = 32'h55AA; tick(); idle();
    chk("R11", "stamp", stamp_o, 32'h55AA);
    chk("R9", "no error", err_o, 0);
    release_c = 1; tick(); idle();
    chk("R8", "state", state_o, 0);
    chk("R8", "cleared", {class_o, warp_o, bypass_o, lane_mask_o}, {3'd0, 6'h3F, 1'b0, 32'd0});
    chk("R8", "size/pc", {size_o, pc_o}, 0);
    chk("R11", "stamp cleared", stamp_o, 0);
    chk("R10", "lat cleared", latency_o, 0);
  endtask

  task automatic t_classes();
    do_reset();
    dispatch(1, 0, 1, 0, 6'd1, 8'd8, 32'h10, 0);
    chk("R3", "atomic", class_o, 4);
    do_reset();
    dispatch(0, 1, 0, 0, 6'd2, 8'd8, 32'h20, 0);
    chk("R3", "store", class_o, 2);
    chk("R3", "no err", err_o, 0);
  endtask

  task automatic t_fence();
    do_reset();
    dispatch(0, 0, 0, 1, 6'd9, 8'd0, 32'h40, 0);
    chk("R3", "fence class", class_o, 3);
    fence_start = 1; tick(); idle();
    chk("R6", "fencing", state_o, 3);
    chk("R10", "lat fence", latency_o, 1);
    tick(); tick();
    chk("R10", "lat fence later", latency_o, 3);
    fence_arrive = 1; tick(); idle();
    chk("R6", "fence done", state_o, 4);
    release_c = 1; tick(); idle();
    chk("R8", "fence release", state_o, 0);
    chk("R9", "fence no err", err_o, 0);
  endtask

  task automatic t_bad_desc();
    do_reset();
    dispatch(0, 1, 1, 0, 6'd3, 8'd1, 32'h1, 0);
    chk("R4", "wr+swap", {state_o, err_o}, {3'd0, 1'b1});
    do_reset();
    dispatch(0, 0, 1, 1, 6'd3, 8'd1, 32'h1, 0);
    chk("R4", "fence+swap", {state_o, err_o}, {3'd0, 1'b1});
    do_reset();
    dispatch(0, 0, 0, 0, 6'd3, 8'd1, 32'h1, 0);
    chk("R4", "no kind", {state_o, err_o, class_o}, {3'd0, 1'b1, 3'd0});
    do_reset();
    dispatch(1, 1, 0, 0, 6'd3, 8'd1, 32'h1, 0);
    chk("R4", "two kinds", {state_o, err_o}, {3'd0, 1'b1});
  endtask

  task automatic t_illegal();
    do_reset();
    coalesce = 1; tick(); idle();
    chk("R9", "coal in empty", {state_o, err_o}, {3'd0, 1'b1});
    tick();
    chk("R9", "err sticky", err_o, 1);
    do_reset();
    dispatch(1, 0, 0, 0, 6'd7, 8'd2, 32'h70, 0);
    dispatch(0, 1, 0, 0, 6'd8, 8'd3, 32'h80, 1);
    chk("R2", "second disp ignored", {state_o, warp_o, class_o, err_o}, {3'd1, 6'd7, 3'd1, 1'b1});
    do_reset();
    dispatch(1, 0, 0, 0, 6'd7, 8'd2, 32'h70, 0);
    release_c = 1; tick(); idle();
    chk("R9", "release in disp", {state_o, err_o}, {3'd1, 1'b1});
    do_reset();
    dispatch(1, 0, 0, 0, 6'd7, 8'd2, 32'h70, 0);
    coalesce = 1; fence_start = 1; acc_cnt = 6'd3; tick(); idle();
    chk("R9", "two cmds", {state_o, err_o, pending_o}, {3'd1, 1'b1, 6'd0});
    do_reset();
    dispatch(1, 0, 0, 0, 6'd7, 8'd2, 32'h70, 0);
    fence_arrive = 1; tick(); idle();
    chk("R6", "arrive in disp", {state_o, err_o}, {3'd1, 1'b1});
    do_reset();
    dispatch(1, 0, 0, 0, 6'd7, 8'd2, 32'h70, 0);
    coalesce = 1; acc_cnt = 6'd1; tick(); idle();
    release_c = 1; tick(); idle();
    chk("R8", "release undrained", {state_o, err_o, pending_o}, {3'd2, 1'b1, 6'd1});
    do_reset();
    lane_set = 1; lane_mask = 32'hFFFF_0000; tick(); idle();
    chk("R13", "lane in empty err", err_o, 1);
    dispatch(1, 0, 0, 0, 6'd4, 8'd2, 32'h70, 0);
    chk("R13", "lane ignored", lane_mask_o, 0);
    coalesce = 1; acc_cnt = 6'd0; tick(); idle();
    chk("R12", "zero-access done", done_o, 1);
    lane_set = 1; lane_mask = 32'h1; tick(); idle();
    chk("R13", "lane in coal ignored", lane_mask_o, 0);
    do_reset();
    dispatch(1, 0, 0, 0, 6'd4, 8'd2, 32'h70, 0);
    coalesce = 1; acc_cnt = 6'd0; tick(); idle();
    acc_cp = 1; tick(); idle();
    chk("R7", "complete underflow", {err_o, pending_o, translated_o}, {1'b1, 6'd0, 6'd0});
    do_reset();
    dispatch(1, 0, 0, 0, 6'd4, 8'd2, 32'h70, 0);
    coalesce = 1; acc_cnt = 6'd0; tick(); idle();
    acc_tr = 1; tick(); idle();
    chk("R7", "translate underflow", {err_o, pending_o, translated_o}, {1'b1, 6'd0, 6'd0});
  endtask

  initial begin
    idle();
    t_reset();
    t_load_path();
    t_classes();
    t_fence();
    t_bad_desc();
    t_illegal();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(4 * 100000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule